// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block produces the command stream that brings an SDRAM device into a usable state. It runs after reset, or after a channel leaves deep power-down. For each channel it issues one precharge-all-banks command, then waits a programmed number of cycles. It then issues a programmed number of auto-refresh commands, each followed by a programmed number of idle cycles. Every cycle that carries neither of those commands carries a deselect.

Software writes three timing fields:

- the precharge wait,
- the gap after each refresh,
- the refresh count.

Software then pulses one of two start controls:

- a per-channel start bit, which runs the sequence on that channel alone (used when a channel leaves deep power-down);
- a global start bit, which runs it on every channel at once (used after reset).

A per-channel busy flag shows that a sequence is in progress and clears itself when the sequence ends. The timing fields are captured at start, so later writes do not affect a run already in progress.

Each channel runs a five-state machine:

- IDLE: deselect, not busy.
- PALL: precharge-all.
- PWAIT: precharge wait, deselect.
- AREF: auto-refresh.
- RGAP: gap after a refresh, deselect.

Transitions:

- IDLE→PALL on an accepted start.
- PALL→PWAIT when the wait is non-zero; PALL→AREF when it is zero.
- PWAIT→AREF when the wait counter expires.
- AREF→RGAP when the gap is non-zero.
- AREF→AREF, back-to-back, when the gap is zero and refreshes remain.
- AREF→IDLE when the gap is zero and this was the last refresh.
- RGAP→AREF when the gap expires and refreshes remain.
- RGAP→IDLE when the gap expires after the last refresh.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset every channel has busy = 0 and command = deselect (2'b00).
- R2: The command output per channel uses deselect = 2'b00, precharge-all = 2'b01, auto-refresh = 2'b10; the value 2'b11 never appears, and deselect is driven on every cycle that carries neither of the other two.
- R3: A start accepted at a clock edge puts precharge-all on the channel's command output in the cycle that follows that edge, for exactly one cycle.
- R4: Exactly P deselect cycles follow the precharge-all before the first auto-refresh, where P is the precharge wait field (P = 0 gives an auto-refresh directly after it).
- R5: Each auto-refresh is followed by exactly G deselect cycles, where G is the gap field; with G = 0 the refreshes are back to back.
- R6: The number of auto-refresh commands equals the count field for values 1 to 15; a count of 0 gives one auto-refresh.
- R7: Busy is 1 from the precharge-all cycle through the last gap cycle after the final refresh, and returns to 0 by itself in the cycle after that.
- R8: A per-channel start bit runs the sequence on that channel only; other channels keep their command and busy unchanged.
- R9: The global start bit starts the sequence on every idle channel in the same cycle.
- R10: A start on a channel whose busy is 1 (including its final busy cycle) is ignored: that run is neither restarted nor lengthened.
- R11: The three timing fields are captured when a run starts; changing them during the run does not alter that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_ch | input | NUM_CH | Per-channel start pulse |
| start_all | input | 1 | Start pulse for all channels |
| cfg_pre_wait | input | PW_W | Deselect cycles after precharge-all |
| cfg_ref_gap | input | GAP_W | Deselect cycles after each auto-refresh |
| cfg_ref_cnt | input | CNT_W | Number of auto-refreshes (0 treated as 1) |
| busy | output | NUM_CH | Sequence in progress, per channel |
| cmd | output | 2*NUM_CH | Command per channel, channel i at bits [2i+1:2i] |

## Verification
The bench compares every cycle of both channels' command and busy outputs against a cycle-exact expected stream. Zero-length waits and back-to-back refreshes catch an off-by-one counter, which would insert or drop deselect cycles. A count of zero catches a sequence that would issue no refresh or sixteen of them. A restart fired on the exact last busy cycle catches a design that restarts early or stretches the run. Rewriting the fields mid-run catches timing that is not latched, which would shift the later refreshes. Staggered per-channel and global starts catch channels that leak into one another.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_DSL = 2'b00,
        CMD_PRA = 2'b01,
        CMD_RFA = 2'b10
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PALL,
        ST_PWAIT,
        ST_AREF,
        ST_RGAP
    } init_state_e;

endpackage

// File: rtl/sdram_init_trig.sv
module sdram_init_trig #(
    parameter int NUM_CH = 2
) (
    input  logic [NUM_CH-1:0] start_ch,
    input  logic              start_all,
    output logic [NUM_CH-1:0] go
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_go
        assign go[g] = start_ch[g] | start_all;
    end

endmodule

// File: rtl/sdram_init_chan.sv
module sdram_init_chan
    import sdram_init_pkg::*;
#(
    parameter int PW_W  = 4,
    parameter int GAP_W = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [PW_W-1:0]  cfg_pre,
    input  logic [GAP_W-1:0] cfg_gap,
    input  logic [CNT_W-1:0] cfg_cnt,
    output logic             busy,
    output logic [1:0]       cmd
);

    localparam int WC_W = (PW_W > GAP_W) ? PW_W : GAP_W;

    init_state_e      state;
    logic [WC_W-1:0]  wcnt;
    logic [GAP_W-1:0] gap_r;
    logic [CNT_W-1:0] rcnt;

    // state register and captured timing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            wcnt  <= '0;
            gap_r <= '0;
            rcnt  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        state <= ST_PALL;
                        wcnt  <= WC_W'(cfg_pre);
                        gap_r <= cfg_gap;
                        rcnt  <= (cfg_cnt == '0) ? CNT_W'(1) : cfg_cnt;
                    end
                end
                ST_PALL: begin
                    state <= (wcnt == '0) ? ST_AREF : ST_PWAIT;
                end
                ST_PWAIT: begin
                    wcnt <= wcnt - 1'b1;
                    if (wcnt == WC_W'(1)) state <= ST_AREF;
                end
                ST_AREF: begin
                    rcnt <= rcnt - 1'b1;
                    if (gap_r != '0) begin
                        state <= ST_RGAP;
                        wcnt  <= WC_W'(gap_r);
                    end else if (rcnt == CNT_W'(1)) begin
                        state <= ST_IDLE;
                    end
                end
                ST_RGAP: begin
                    wcnt <= wcnt - 1'b1;
                    if (wcnt == WC_W'(1))
                        state <= (rcnt == '0) ? ST_IDLE : ST_AREF;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        unique case (state)
            ST_IDLE:  begin busy = 1'b0; cmd = CMD_DSL; end
            ST_PALL:  begin busy = 1'b1; cmd = CMD_PRA; end
            ST_PWAIT: begin busy = 1'b1; cmd = CMD_DSL; end
            ST_AREF:  begin busy = 1'b1; cmd = CMD_RFA; end
            ST_RGAP:  begin busy = 1'b1; cmd = CMD_DSL; end
            default:  begin busy = 1'b0; cmd = CMD_DSL; end
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
    parameter int NUM_CH = 2,
    parameter int PW_W   = 4,
    parameter int GAP_W  = 4,
    parameter int CNT_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   start_ch,
    input  logic                start_all,
    input  logic [PW_W-1:0]     cfg_pre_wait,
    input  logic [GAP_W-1:0]    cfg_ref_gap,
    input  logic [CNT_W-1:0]    cfg_ref_cnt,
    output logic [NUM_CH-1:0]   busy,
    output logic [2*NUM_CH-1:0] cmd
);

    logic [NUM_CH-1:0] go;

    sdram_init_trig #(.NUM_CH(NUM_CH)) u_trig (
        .start_ch  (start_ch),
        .start_all (start_all),
        .go        (go)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        sdram_init_chan #(
            .PW_W  (PW_W),
            .GAP_W (GAP_W),
            .CNT_W (CNT_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .go      (go[g]),
            .cfg_pre (cfg_pre_wait),
            .cfg_gap (cfg_ref_gap),
            .cfg_cnt (cfg_ref_cnt),
            .busy    (busy[g]),
            .cmd     (cmd[2*g +: 2])
        );
    end

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
    parameter int NUM_CH = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_CH-1:0]   start_ch,
    input logic                start_all,
    input logic [NUM_CH-1:0]   busy,
    input logic [2*NUM_CH-1:0] cmd
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cmd[2*g +: 2] != 2'b11);

        assert_idle_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !busy[g] |-> cmd[2*g +: 2] == 2'b00);

        assert_start_pall_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (start_ch[g] || start_all) && !busy[g] |=> cmd[2*g +: 2] == 2'b01);

        assert_busy_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
            busy[g] |=> cmd[2*g +: 2] != 2'b01);

        assert_refresh_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cmd[2*g +: 2] == 2'b10 |-> busy[g]);
    end

endmodule

bind sdram_init_seq sdram_init_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ch  (start_ch),
    .start_all (start_all),
    .busy      (busy),
    .cmd       (cmd)
);

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] start_ch = '0;
    logic       start_all = 1'b0;
    logic [3:0] cfg_pre_wait = '0;
    logic [3:0] cfg_ref_gap = '0;
    logic [3:0] cfg_ref_cnt = '0;
    logic [1:0] busy;
    logic [3:0] cmd;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    logic [1:0] q0[$];
    logic [1:0] q1[$];
    logic [1:0] mbusy = '0;

    always #2.5 clk = ~clk;

    sdram_init_seq uut (
        .clk(clk), .rst_n(rst_n), .start_ch(start_ch), .start_all(start_all),
        .cfg_pre_wait(cfg_pre_wait), .cfg_ref_gap(cfg_ref_gap),
        .cfg_ref_cnt(cfg_ref_cnt), .busy(busy), .cmd(cmd)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Builds the expected stream of one run (R2 R4 R5 R6 R7)
    task automatic push_seq(input int ch, input int p, input int g, input int n);
        logic [1:0] items[$];
        if (n == 0) n = 1;
        items.push_back(2'b01);
        for (int i = 0; i < p; i++) items.push_back(2'b00);
        for (int r = 0; r < n; r++) begin
            items.push_back(2'b10);
            for (int i = 0; i < g; i++) items.push_back(2'b00);
        end
        foreach (items[k]) begin
            if (ch == 0) q0.push_back(items[k]); else q1.push_back(items[k]);
        end
    endtask

    // Called at a negedge; channels busy now ignore the pulse (R10)
    task automatic fire(input logic [1:0] mask, input logic all,
                        input int p, input int g, input int n);
        cfg_pre_wait = 4'(p);
        cfg_ref_gap  = 4'(g);
        cfg_ref_cnt  = 4'(n);
        start_ch  = mask;
        start_all = all;
        if ((all || mask[0]) && !mbusy[0] && q0.size() == 0) push_seq(0, p, g, n);
        if ((all || mask[1]) && !mbusy[1] && q1.size() == 0) push_seq(1, p, g, n);
        @(negedge clk);
        start_ch  = '0;
        start_all = 1'b0;
    endtask

    task automatic drain();
        while (q0.size() != 0 || q1.size() != 0 || mbusy != 2'b00) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Scoreboard monitor: every cycle, each channel against its queue
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                for (int c = 0; c < 2; c++) begin
                    logic [1:0] e;
                    logic       eb;
                    eb = 1'b0;
                    e  = 2'b00;
                    if (c == 0 && q0.size() != 0) begin e = q0.pop_front(); eb = 1'b1; end
                    if (c == 1 && q1.size() != 0) begin e = q1.pop_front(); eb = 1'b1; end
                    mbusy[c] = eb;
                    check($sformatf("R2 R4 R5 R6 R8 cmd ch%0d", c), int'(cmd[2*c +: 2]), int'(e));
                    check($sformatf("R7 busy ch%0d", c), int'(busy[c]), int'(eb));
                end
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", int'(busy), 0);
        check("R1 cmd", int'(cmd), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after release", int'(cmd), 0);

        // R3 R4 R5 R6 R8: channel 0 alone
        fire(2'b01, 1'b0, 2, 1, 3);
        drain();

        // R9 R4 R5: global start, zero waits, back-to-back
        fire(2'b00, 1'b1, 0, 0, 4);
        drain();

        // R6: count of zero yields one refresh
        fire(2'b00, 1'b1, 1, 2, 0);
        drain();

        // R11 R10 R8: long run on ch1, fields rewritten and ch1 re-fired mid-run
        fire(2'b10, 1'b0, 5, 3, 15);
        repeat (10) @(negedge clk);
        fire(2'b11, 1'b0, 1, 0, 2);
        repeat (7) @(negedge clk);
        cfg_pre_wait = 4'd9;
        cfg_ref_gap  = 4'd7;
        cfg_ref_cnt  = 4'd1;
        fire(2'b10, 1'b0, 9, 7, 1);
        drain();

        // R10: re-fire on the final busy cycle is ignored
        fire(2'b01, 1'b0, 1, 1, 2);
        while (!(mbusy[0] && q0.size() == 0)) @(negedge clk);
        fire(2'b01, 1'b0, 3, 3, 3);
        drain();
        // idle again: a fresh start is accepted (R3)
        fire(2'b01, 1'b0, 0, 2, 2);
        drain();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule